// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of one bus function. A host port presents an 8-bit byte offset, a length code for 1, 2 or 4 bytes, a write flag and 32 bits of write data. Writes are split into byte lanes. Each lane passes a write-protect map chosen by the header-type byte, and the command byte has its reserved bits cleared. Full aligned dword writes to a sized base-address slot or to the expansion-ROM slot bypass the byte map. Software can therefore write all ones and read back the region size: the stored value is forced to the region alignment, and the type bits or the ROM enable bit are kept.

Reads return little-endian data one clock after the request. A dword read too close to the top of the space falls back to a word read, and a word read at the last offset falls back to a byte read. The command register, the six base-address dwords and the ROM dword are driven out continuously for an address decoder next to the block.

Identity, class, subsystem and header-type bytes take their reset values from parameters. Region sizes and type bits are also parameters. Every other byte resets to zero. There is no state machine: each access is decoded as one of four kinds (idle, base-address dword, ROM dword, plain bytes) and completes in the clock cycle in which it is presented.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, offsets 0x00-0x03 hold the identity dword, 0x08-0x0B the class/revision dword, 0x0E the header-type byte and 0x2C-0x2F the subsystem dword, all little-endian. The low byte of each sized base-address dword holds that slot's type bits, and every other byte is zero.
- R2: An aligned 4-byte write (length code 2 or 3) at 0x10, 0x14, 0x18, 0x1C, 0x20 or 0x24 whose slot has a nonzero size stores (data AND NOT(size-1)) OR type bits, for either header type.
- R3: An aligned 4-byte write at 0x30 with a nonzero ROM size stores data AND (NOT(size-1) OR 1), which keeps bit 0 (ROM enable).
- R4: A 4-byte write to a slot of size zero, or at an unaligned offset, takes the plain byte path of R5/R6.
- R5: With header type 0x00 or 0x80, byte writes to 0x00-0x03, 0x06-0x0B, 0x0E, 0x10-0x27, 0x2C-0x33 and 0x3D have no effect. All other bytes take the written value.
- R6: With any other header type, byte writes to 0x00-0x03, 0x06-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D have no effect. All other bytes, the base-address range included, take the written value.
- R7: A byte written to offset 0x05 (command high byte) keeps only bits 2:0, so command bits 15:11 always read zero.
- R8: A multi-byte write stores the lowest data byte at the given offset and the following bytes at increasing offsets. It stops after offset 0xFF and never wraps to 0x00.
- R9: Length code 0 reads one byte, code 1 two bytes, codes 2 and 3 four bytes, little-endian and zero-extended. A 4-byte read above 0xFC is served as a 2-byte read, and a 2-byte read above 0xFE as a 1-byte read.
- R10: Read data appears on rd_data at the clock edge that takes the read, and holds unchanged through writes and idle cycles.
- R11: cmd_o shows bytes 0x05:0x04, bar_o slot n shows the dword at 0x10+4n, and rom_o the dword at 0x30. Each reflects a write from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset into the space |
| acc_len | input | 2 | Length code: 0 = 1, 1 = 2, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, lowest byte first |
| rd_data | output | 32 | Registered read result |
| cmd_o | output | 16 | Command register |
| bar_o | output | 192 | Six base-address dwords, slot 0 in bits 31:0 |
| rom_o | output | 32 | Expansion-ROM dword |

## Verification
A write updates storage at the edge that takes it, so the exported cmd_o, bar_o and rom_o are checked on the falling edge after that edge, and a read issued on the next cycle returns the new bytes. A read's result is registered once and is sampled on the falling edge that follows the edge that took the read. It is then checked again after a later write and an idle cycle to confirm that it holds. The bench drives the same traffic into a normal-header and a bridge-header instance, sweeps a byte write of 0xFF over all 256 offsets and reads each one back. Each byte's expected value is computed from the protect maps, the reset parameters and the command mask.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_BAR_DW,
        ACC_ROM_DW,
        ACC_BYTES
    } acc_kind_e;

    localparam int LANES     = 4;
    localparam int BAR_SLOTS = 6;

    function automatic logic hdr_is_device(input logic [7:0] hdr);
        return (hdr == 8'h00) || (hdr == 8'h80);
    endfunction

    function automatic logic byte_is_ro(input logic [7:0] hdr, input logic [7:0] a);
        logic ro;
        ro = (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0B) || (a == 8'h0E) ||
             (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
        if (hdr_is_device(hdr))
            ro = ro || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
        else
            ro = ro || (a >= 8'h38 && a <= 8'h3B);
        return ro;
    endfunction

    function automatic logic [7:0] keep_mask(input logic [7:0] a);
        return (a == 8'h05) ? 8'h07 : 8'hFF;
    endfunction

    function automatic logic [2:0] len_bytes(input logic [1:0] code);
        return (code == 2'd0) ? 3'd1 : (code == 2'd1) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
    import cfg_space_pkg::*;
#(
    parameter logic [BAR_SLOTS-1:0][31:0] BAR_SIZE = '0,
    parameter logic [BAR_SLOTS-1:0][3:0]  BAR_TYPE = '0,
    parameter logic [31:0]                ROM_SIZE = 32'h0
) (
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [7:0]                  acc_off,
    input  logic [1:0]                  acc_len,
    input  logic [31:0]                 acc_wdata,
    input  logic [7:0]                  hdr_type,
    output logic [LANES-1:0]            lane_we,
    output logic [LANES-1:0][7:0]       lane_addr,
    output logic [LANES-1:0][7:0]       lane_data
);

    acc_kind_e   kind;
    logic        slot_hit;
    logic [31:0] slot_size;
    logic [3:0]  slot_type;
    logic [31:0] bar_val;
    logic [31:0] rom_val;
    logic [2:0]  nbytes;

    always_comb begin
        slot_hit  = 1'b0;
        slot_size = 32'h0;
        slot_type = 4'h0;
        for (int s = 0; s < BAR_SLOTS; s++) begin
            if (acc_off == 8'(16 + 4 * s)) begin
                slot_hit  = 1'b1;
                slot_size = BAR_SIZE[s];
                slot_type = BAR_TYPE[s];
            end
        end
    end

    always_comb begin
        kind = ACC_IDLE;
        if (acc_valid && acc_write) begin
            kind = ACC_BYTES;
            if (acc_len[1]) begin
                if (slot_hit && slot_size != 32'h0)
                    kind = ACC_BAR_DW;
                else if (acc_off == 8'h30 && ROM_SIZE != 32'h0)
                    kind = ACC_ROM_DW;
            end
        end
    end

    assign bar_val = (acc_wdata & ~(slot_size - 32'h1)) | {28'h0, slot_type};
    assign rom_val = acc_wdata & (~(ROM_SIZE - 32'h1) | 32'h1);
    assign nbytes  = len_bytes(acc_len);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [8:0] sum;
            sum          = {1'b0, acc_off} + 9'(i);
            lane_addr[i] = sum[7:0];
            lane_we[i]   = 1'b0;
            lane_data[i] = 8'h00;
            unique case (kind)
                ACC_IDLE: begin
                    lane_we[i] = 1'b0;
                end
                ACC_BAR_DW: begin
                    lane_we[i]   = 1'b1;
                    lane_data[i] = bar_val[8*i +: 8];
                end
                ACC_ROM_DW: begin
                    lane_we[i]   = 1'b1;
                    lane_data[i] = rom_val[8*i +: 8];
                end
                ACC_BYTES: begin
                    lane_we[i]   = (3'(i) < nbytes) && !sum[8] &&
                                   !byte_is_ro(hdr_type, sum[7:0]);
                    lane_data[i] = acc_wdata[8*i +: 8] & keep_mask(sum[7:0]);
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
    import cfg_space_pkg::*;
#(
    parameter logic [31:0]                VEN_DEV_ID = 32'h0,
    parameter logic [31:0]                CLASS_REV  = 32'h0,
    parameter logic [7:0]                 HDR_TYPE   = 8'h00,
    parameter logic [31:0]                SUBSYS_ID  = 32'h0,
    parameter logic [BAR_SLOTS-1:0][31:0] BAR_SIZE   = '0,
    parameter logic [BAR_SLOTS-1:0][3:0]  BAR_TYPE   = '0,
    parameter int                         NBYTES     = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       lane_we,
    input  logic [LANES-1:0][7:0]  lane_addr,
    input  logic [LANES-1:0][7:0]  lane_data,
    output logic [NBYTES-1:0][7:0] cfg_q
);

    function automatic logic [7:0] rst_byte(input int j);
        logic [7:0] v;
        v = 8'h00;
        if (j <= 3)                     v = VEN_DEV_ID[8*j +: 8];
        else if (j >= 8 && j <= 11)     v = CLASS_REV[8*(j-8) +: 8];
        else if (j == 14)               v = HDR_TYPE;
        else if (j >= 44 && j <= 47)    v = SUBSYS_ID[8*(j-44) +: 8];
        else if (j >= 16 && j <= 39 && (j % 4) == 0 && BAR_SIZE[(j-16)/4] != 32'h0)
            v = {4'h0, BAR_TYPE[(j-16)/4]};
        return v;
    endfunction

    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        localparam logic [7:0] RST_VAL = rst_byte(j);
        logic       hit;
        logic [7:0] nxt;

        always_comb begin
            hit = 1'b0;
            nxt = cfg_q[j];
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i] && lane_addr[i] == 8'(j)) begin
                    hit = 1'b1;
                    nxt = lane_data[i];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[j] <= RST_VAL;
            else if (hit)
                cfg_q[j] <= nxt;
        end
    end

endmodule

// File: rtl/cfg_rd_path.sv
module cfg_rd_path
    import cfg_space_pkg::*;
#(
    parameter int NBYTES = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [7:0]             acc_off,
    input  logic [1:0]             acc_len,
    input  logic [NBYTES-1:0][7:0] cfg_q,
    output logic [31:0]            rd_data
);

    logic [LANES-1:0][7:0] rb;
    logic [2:0]            eff;
    logic [31:0]           rd_nxt;

    always_comb begin
        for (int i = 0; i < LANES; i++)
            rb[i] = cfg_q[acc_off + 8'(i)];
    end

    always_comb begin
        if (acc_len[1] && acc_off <= 8'hFC)
            eff = 3'd4;
        else if (acc_len != 2'd0 && acc_off <= 8'hFE)
            eff = 3'd2;
        else
            eff = 3'd1;
    end

    always_comb begin
        unique case (eff)
            3'd4:    rd_nxt = {rb[3], rb[2], rb[1], rb[0]};
            3'd2:    rd_nxt = {16'h0, rb[1], rb[0]};
            default: rd_nxt = {24'h0, rb[0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 32'h0;
        else if (acc_valid && !acc_write)
            rd_data <= rd_nxt;
    end

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
    import cfg_space_pkg::*;
#(
    parameter logic [31:0]                VEN_DEV_ID = 32'h5A1C_17E3,
    parameter logic [31:0]                CLASS_REV  = 32'h0200_0001,
    parameter logic [7:0]                 HDR_TYPE   = 8'h00,
    parameter logic [31:0]                SUBSYS_ID  = 32'h0001_17E3,
    parameter logic [BAR_SLOTS-1:0][31:0] BAR_SIZE   = {32'h0, 32'h0, 32'h0, 32'h0,
                                                        32'h0000_1000, 32'h0000_0100},
    parameter logic [BAR_SLOTS-1:0][3:0]  BAR_TYPE   = {4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1},
    parameter logic [31:0]                ROM_SIZE   = 32'h0000_0800
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic [7:0]              acc_off,
    input  logic [1:0]              acc_len,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             rd_data,
    output logic [15:0]             cmd_o,
    output logic [BAR_SLOTS*32-1:0] bar_o,
    output logic [31:0]             rom_o
);

    localparam int NBYTES   = 256;
    localparam int BAR_BASE = 16;
    localparam int ROM_BASE = 48;

    logic [LANES-1:0]       lane_we;
    logic [LANES-1:0][7:0]  lane_addr;
    logic [LANES-1:0][7:0]  lane_data;
    logic [NBYTES-1:0][7:0] cfg_q;

    cfg_wr_decode #(
        .BAR_SIZE (BAR_SIZE),
        .BAR_TYPE (BAR_TYPE),
        .ROM_SIZE (ROM_SIZE)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_off   (acc_off),
        .acc_len   (acc_len),
        .acc_wdata (acc_wdata),
        .hdr_type  (cfg_q[14]),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_data (lane_data)
    );

    cfg_byte_array #(
        .VEN_DEV_ID (VEN_DEV_ID),
        .CLASS_REV  (CLASS_REV),
        .HDR_TYPE   (HDR_TYPE),
        .SUBSYS_ID  (SUBSYS_ID),
        .BAR_SIZE   (BAR_SIZE),
        .BAR_TYPE   (BAR_TYPE),
        .NBYTES     (NBYTES)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_data (lane_data),
        .cfg_q     (cfg_q)
    );

    cfg_rd_path #(
        .NBYTES (NBYTES)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_off   (acc_off),
        .acc_len   (acc_len),
        .cfg_q     (cfg_q),
        .rd_data   (rd_data)
    );

    assign cmd_o = {cfg_q[5], cfg_q[4]};
    assign rom_o = {cfg_q[ROM_BASE+3], cfg_q[ROM_BASE+2], cfg_q[ROM_BASE+1], cfg_q[ROM_BASE]};

    for (genvar s = 0; s < BAR_SLOTS; s++) begin : g_bar
        assign bar_o[32*s +: 32] = {cfg_q[BAR_BASE+4*s+3], cfg_q[BAR_BASE+4*s+2],
                                    cfg_q[BAR_BASE+4*s+1], cfg_q[BAR_BASE+4*s]};
    end

endmodule

// File: rtl/cfg_space_regs_chk.sv
module cfg_space_regs_chk
    import cfg_space_pkg::*;
#(
    parameter logic [7:0]                 HDR_TYPE = 8'h00,
    parameter logic [BAR_SLOTS-1:0][31:0] BAR_SIZE = '0,
    parameter logic [BAR_SLOTS-1:0][3:0]  BAR_TYPE = '0,
    parameter logic [31:0]                ROM_SIZE = 32'h0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    acc_write,
    input logic [1:0]              acc_len,
    input logic [31:0]             rd_data,
    input logic [15:0]             cmd_o,
    input logic [BAR_SLOTS*32-1:0] bar_o,
    input logic [31:0]             rom_o
);

    localparam bit IS_DEV = (HDR_TYPE == 8'h00) || (HDR_TYPE == 8'h80);

    // R7
    cmd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[15:11] == 5'h0);

    // R9
    byte_read_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !acc_write && acc_len == 2'd0) |-> rd_data[31:8] == 24'h0);

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid && !acc_write) |-> $stable(rd_data));

    for (genvar s = 0; s < BAR_SLOTS; s++) begin : g_bar_chk
        if (IS_DEV && BAR_SIZE[s] != 32'h0) begin : g_on
            // R2
            bar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bar_o[32*s +: 32] & (BAR_SIZE[s] - 32'h1)) == {28'h0, BAR_TYPE[s]});
        end
    end

    if (IS_DEV && ROM_SIZE > 32'h1) begin : g_rom_chk
        // R3
        rom_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rom_o & (ROM_SIZE - 32'h1) & ~32'h1) == 32'h0);
    end

endmodule

bind cfg_space_regs cfg_space_regs_chk #(
    .HDR_TYPE (HDR_TYPE),
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE),
    .ROM_SIZE (ROM_SIZE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_len   (acc_len),
    .rd_data   (rd_data),
    .cmd_o     (cmd_o),
    .bar_o     (bar_o),
    .rom_o     (rom_o)
);

// File: tb/test_cfg_space_regs.sv
module test_cfg_space_regs;

    localparam logic [31:0] VD  = 32'h5A1C_17E3;
    localparam logic [31:0] CR  = 32'h0200_0001;
    localparam logic [31:0] SUB = 32'h0001_17E3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic         acc_write = 1'b0;
    logic [7:0]   acc_off = 8'h0;
    logic [1:0]   acc_len = 2'd0;
    logic [31:0]  acc_wdata = 32'h0;
    logic [31:0]  rd0, rd1, rom0, rom1;
    logic [15:0]  cmd0, cmd1;
    logic [191:0] bar0, bar1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_space_regs #(.HDR_TYPE(8'h00)) i_cfg_space_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_off(acc_off), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_data(rd0), .cmd_o(cmd0), .bar_o(bar0), .rom_o(rom0));

    cfg_space_regs #(.HDR_TYPE(8'h01)) i_cfg_space_regs_br (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_off(acc_off), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_data(rd1), .cmd_o(cmd1), .bar_o(bar1), .rom_o(rom1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [1:0] len, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_off = off; acc_len = len; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [1:0] len);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_off = off; acc_len = len;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [7:0] rst_byte(input int a, input logic [7:0] hdr);
        if (a <= 3)                return VD[8*a +: 8];
        if (a >= 8 && a <= 11)     return CR[8*(a-8) +: 8];
        if (a == 14)               return hdr;
        if (a >= 44 && a <= 47)    return SUB[8*(a-44) +: 8];
        if (a == 16)               return 8'h01;
        if (a == 20)               return 8'h08;
        return 8'h00;
    endfunction

    function automatic bit ro_dev(input int a);
        return a <= 3 || (a >= 6 && a <= 11) || a == 14 || (a >= 16 && a <= 39) ||
               (a >= 44 && a <= 51) || a == 61;
    endfunction

    function automatic bit ro_br(input int a);
        return a <= 3 || (a >= 6 && a <= 11) || a == 14 || (a >= 44 && a <= 47) ||
               (a >= 56 && a <= 59) || a == 61;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state via reads and exports
        rd(8'h00, 2'd2);  chk("R1 ident", rd0, VD);
        rd(8'h08, 2'd2);  chk("R1 class", rd0, CR);
        rd(8'h2C, 2'd2);  chk("R1 subsys", rd1, SUB);
        rd(8'h0E, 2'd0);  chk("R1 hdr dev", rd0, 32'h00); chk("R1 hdr br", rd1, 32'h01);
        chk("R1 cmd", {16'h0, cmd0}, 32'h0);
        chk("R1 bar0", bar0[31:0], 32'h1);  chk("R1 bar1", bar1[63:32], 32'h8);
        chk("R1 rom", rom0, 32'h0);

        // R5 R6 R7 sweep: 0xFF into every byte, read each back
        for (int a = 0; a < 256; a++) wr(8'(a), 2'd0, 32'hFF);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] keep;
            keep = (a == 5) ? 8'h07 : 8'hFF;
            rd(8'(a), 2'd0);
            chk("R5 sweep", rd0, {24'h0, ro_dev(a) ? rst_byte(a, 8'h00) : keep});
            chk("R6 sweep", rd1, {24'h0, ro_br(a) ? rst_byte(a, 8'h01) : keep});
        end
        chk("R7 cmd mask", {16'h0, cmd0}, 32'h07FF);
        chk("R11 bar0 br", bar1[31:0], 32'hFFFF_FFFF);
        chk("R11 rom br", rom1, 32'hFFFF_FFFF);

        // R2 base-address sizing
        wr(8'h10, 2'd2, 32'hFFFF_FFFF);
        chk("R2 bar0 dev", bar0[31:0], 32'hFFFF_FF01);
        chk("R2 bar0 br", bar1[31:0], 32'hFFFF_FF01);
        wr(8'h14, 2'd3, 32'h1234_5678);
        chk("R2 bar1 dev", bar0[63:32], 32'h1234_5008);
        rd(8'h14, 2'd2);  chk("R2 bar1 read", rd1, 32'h1234_5008);
        wr(8'h10, 2'd2, 32'h0000_C0F3);
        chk("R2 bar0 io", bar0[31:0], 32'h0000_C001);

        // R4 zero-size slot and unaligned dword
        wr(8'h18, 2'd2, 32'hA5A5_A5A5);
        chk("R4 bar2 dev", bar0[95:64], 32'h0);
        chk("R4 bar2 br", bar1[95:64], 32'hA5A5_A5A5);
        wr(8'h12, 2'd2, 32'hDEAD_BEEF);
        chk("R4 unaligned dev", bar0[31:0], 32'h0000_C001);
        chk("R4 unaligned br0", bar1[31:0], 32'hBEEF_C001);
        chk("R4 unaligned br1", bar1[63:32], 32'h1234_DEAD);

        // R3 ROM sizing
        wr(8'h30, 2'd2, 32'h1234_5679);
        chk("R3 rom dev", rom0, 32'h1234_5001);
        chk("R3 rom br", rom1, 32'h1234_5001);
        wr(8'h30, 2'd2, 32'hFFFF_FFFE);
        chk("R3 rom off", rom0, 32'hFFFF_F800);

        // R8 top-of-space write
        wr(8'hFE, 2'd2, 32'hAABB_CCDD);
        rd(8'hFC, 2'd2);  chk("R8 top dword", rd0, 32'hCCDD_FFFF);
        rd(8'h00, 2'd0);  chk("R8 no wrap", rd0, 32'hE3);
        wr(8'h40, 2'd1, 32'h0000_9A8B);
        rd(8'h40, 2'd2);  chk("R8 word order", rd0, 32'hFFFF_9A8B);

        // R9 fall-back reads and little-endian order
        rd(8'hFE, 2'd2);  chk("R9 dw->w", rd0, 32'h0000_CCDD);
        rd(8'hFF, 2'd2);  chk("R9 dw->b", rd0, 32'h0000_00CC);
        rd(8'hFF, 2'd1);  chk("R9 w->b", rd0, 32'h0000_00CC);
        rd(8'hFD, 2'd2);  chk("R9 fd dw", rd0, 32'h0000_DDFF);
        rd(8'h02, 2'd1);  chk("R9 word", rd0, 32'h0000_5A1C);

        // R10 hold through write and idle
        wr(8'h41, 2'd0, 32'h11);
        @(negedge clk);
        chk("R10 hold", rd0, 32'h0000_5A1C);

        // R11 command export
        wr(8'h04, 2'd1, 32'h0000_0000);
        chk("R11 cmd clr", {16'h0, cmd0}, 32'h0);
        wr(8'h05, 2'd0, 32'h0000_000C);
        chk("R7 cmd hi", {16'h0, cmd0}, 32'h0400);
        wr(8'h04, 2'd0, 32'h0000_0006);
        chk("R11 cmd lo", {16'h0, cmd1}, 32'h0406);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule